// File: doc/BRIEF.md
# Lockable Memory-Interface Ownership Registers

This block is a small set of configuration registers for an external-memory interface that two CPUs and a DMA engine share. It sits on a simple word-addressed register bus. The bus has an address, write data, a write strobe, a read strobe and a privileged-write enable. A requester-ID bit tells the block which CPU issued a write. The block decides who owns the interface and which kinds of traffic are fenced off. It drives the current owner code and three block flags: one for DMA writes, one for CPU writes and one for CPU instruction fetches.

Writes pass through several guards. The privilege enable gates every register. A soft lock bit and a write-once commit bit protect the owner and protection fields. The owner-select write also needs a 28-bit key in the upper bits of the same data word. The ownership field follows a two-party rule. The secondary CPU may take the interface only while the primary CPU holds it without having grabbed it. The primary CPU may write any owner code. All state is reset by a synchronous active-high reset.

Top module: `mif_own_regs`

## Requirements
- R1: After reset, the lock, commit, owner-select and protection fields are all 0. Every output is 0, and every register reads back 0.
- R2: When `bus_priv` is 0, a write leaves every register unchanged, whatever the offset or data.
- R3: While the lock bit is 1, writes to the owner-select and protection fields are ignored. The lock bit is bit 0 at word offset 0x0, and it stays writable at all times.
- R4: The commit bit is bit 0 at offset 0x2. A privileged write with data bit 0 = 1 sets it. Writing 0 does not clear it, and only reset clears it. While it is 1, writes to the owner-select and protection fields are ignored, whatever the lock bit holds.
- R5: A write to offset 0x4 changes the owner select (data bits [1:0]) only if data bits [31:4] equal 0x93A5CE7. With any other key, the write has no effect.
- R6: Owner codes: 01 means the primary CPU owns the interface, and 10 means the secondary CPU owns it. 00 and 11 both mean the primary CPU owns it but has not grabbed it. A write with `req_id`=1 (secondary CPU) is accepted only when the current code is 00 or 11 and the written code is 10.
- R7: A write with `req_id`=0 (primary CPU) that passes the other guards may set any of the four owner codes.
- R8: The protection register sits at offset 0x8. Bit 2 drives `dma_wr_blk`, bit 1 drives `cpu_wr_blk` and bit 0 drives `fetch_blk`, and 1 means blocked. Data bits above bit 2 are ignored.
- R9: A read returns data one cycle after `bus_rd`. Reserved bits and the key bits [31:4] at offset 0x4 read 0. Unmapped offsets read 0, and writes to them have no effect. `bus_rdata` is 0 in any cycle that does not follow a read.
- R10: `owner_sel` and the block flags are registered. They change on the first clock edge that samples an accepted write, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_priv | input | 1 | Privileged-write enable |
| bus_rd | input | 1 | Read strobe |
| req_id | input | 1 | Writer identity: 0 primary CPU, 1 secondary CPU |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| owner_sel | output | 2 | Current owner code |
| dma_wr_blk | output | 1 | DMA writes blocked |
| cpu_wr_blk | output | 1 | CPU writes blocked |
| fetch_blk | output | 1 | CPU instruction fetches blocked |

## Verification
The bench targets the overlap of the guards.

- Commit is set while the lock is clear. A design that gated on the lock alone would then let protection writes through.
- Writing 0 to commit tests that the bit cannot be cleared by a write.
- Toggling the lock after commit tests that commit does not also freeze the lock.
- The secondary CPU tries every illegal grab: from 01, from 10, and to a code other than 10. A design that let the secondary CPU write freely would show a changed owner.
- A wrong key, and a right key with dirty reserved bits, show whether the key compare covers the full field and whether key bits leak into readback.
- Reads of reserved offsets, and the cycle before a write takes effect, catch wrong decoding and an output that was made combinational.

// File: rtl/mif_own_pkg.sv
package mif_own_pkg;
  localparam int unsigned KEY_LSB = 4;
  localparam logic [27:0] OWN_KEY = 28'h93A5CE7;

  localparam logic [3:0] OFS_LOCK   = 4'h0;
  localparam logic [3:0] OFS_COMMIT = 4'h2;
  localparam logic [3:0] OFS_OWNER  = 4'h4;
  localparam logic [3:0] OFS_PROT   = 4'h8;

  localparam logic [1:0] OWN_IDLE0 = 2'b00;
  localparam logic [1:0] OWN_PRI   = 2'b01;
  localparam logic [1:0] OWN_SEC   = 2'b10;
  localparam logic [1:0] OWN_IDLE3 = 2'b11;

  typedef struct packed {
    logic lock;
    logic commit;
    logic owner;
    logic prot;
  } reg_hit_t;
endpackage

// File: rtl/mif_wr_decode.sv
module mif_wr_decode #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  input  logic                 priv,
  output mif_own_pkg::reg_hit_t hit
);
  import mif_own_pkg::*;

  logic wr_ok;
  assign wr_ok = we & priv;

  always_comb begin
    hit        = '0;
    hit.lock   = wr_ok && (addr == ADDR_W'(OFS_LOCK));
    hit.commit = wr_ok && (addr == ADDR_W'(OFS_COMMIT));
    hit.owner  = wr_ok && (addr == ADDR_W'(OFS_OWNER));
    hit.prot   = wr_ok && (addr == ADDR_W'(OFS_PROT));
  end

  // R2: an unprivileged write selects no register
  p_no_hit_unpriv_r2: assert property (@(posedge clk) disable iff (rst)
    !priv |-> (hit == '0));
  p_hit_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));
endmodule

// File: rtl/mif_owner_sel.sv
module mif_owner_sel #(
  parameter int unsigned OWN_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             req_sec,
  input  logic [OWN_W-1:0] new_val,
  output logic [OWN_W-1:0] owner
);
  import mif_own_pkg::*;

  logic free_now;
  logic grab_ok;
  logic accept;

  assign free_now = (owner == OWN_W'(OWN_IDLE0)) || (owner == OWN_W'(OWN_IDLE3));
  assign grab_ok  = free_now && (new_val == OWN_W'(OWN_SEC));
  assign accept   = wr_en && (!req_sec || grab_ok);

  always_ff @(posedge clk) begin
    if (rst)         owner <= '0;
    else if (accept) owner <= new_val;
  end

  // R6: the secondary CPU cannot take a grabbed interface
  p_no_steal_r6: assert property (@(posedge clk) disable iff (rst)
    (req_sec && !free_now) |=> $stable(owner));
  // R6: a secondary write only ever lands the secondary code
  p_sec_code_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && req_sec && owner != new_val) |=> (owner == OWN_W'(OWN_SEC)) || $stable(owner));
endmodule

// File: rtl/mif_readback.sv
module mif_readback #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OWN_W  = 2,
  parameter int unsigned PROT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lock,
  input  logic              commit,
  input  logic [OWN_W-1:0]  owner,
  input  logic [PROT_W-1:0] prot,
  output logic [DATA_W-1:0] rdata
);
  import mif_own_pkg::*;

  logic [DATA_W-1:0] mux;

  always_comb begin
    mux = '0;
    if (addr == ADDR_W'(OFS_LOCK))        mux[0] = lock;
    else if (addr == ADDR_W'(OFS_COMMIT)) mux[0] = commit;
    else if (addr == ADDR_W'(OFS_OWNER))  mux[OWN_W-1:0] = owner;
    else if (addr == ADDR_W'(OFS_PROT))   mux[PROT_W-1:0] = prot;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= mux;
    else         rdata <= '0;
  end

  // R9: no read, no data
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata == '0));
  // R9: key bits never read back
  p_key_hidden_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rdata[DATA_W-1:KEY_LSB] == '0));
endmodule

// File: rtl/mif_own_regs.sv
module mif_own_regs #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OWN_W  = 2,
  parameter int unsigned PROT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_priv,
  input  logic              bus_rd,
  input  logic              req_id,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [OWN_W-1:0]  owner_sel,
  output logic              dma_wr_blk,
  output logic              cpu_wr_blk,
  output logic              fetch_blk
);
  import mif_own_pkg::*;

  localparam int unsigned KEY_W = DATA_W - KEY_LSB;

  reg_hit_t          hit;
  logic              lock_q;
  logic              commit_q;
  logic [PROT_W-1:0] prot_q;
  logic              guard_open;
  logic              key_ok;

  mif_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .priv(bus_priv), .hit(hit)
  );

  assign guard_open = !lock_q && !commit_q;
  assign key_ok     = (bus_wdata[DATA_W-1:KEY_LSB] == KEY_W'(OWN_KEY));

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q   <= 1'b0;
      commit_q <= 1'b0;
      prot_q   <= '0;
    end else begin
      if (hit.lock)                 lock_q   <= bus_wdata[0];
      if (hit.commit && bus_wdata[0]) commit_q <= 1'b1;
      if (hit.prot && guard_open)   prot_q   <= bus_wdata[PROT_W-1:0];
    end
  end

  mif_owner_sel #(.OWN_W(OWN_W)) u_own (
    .clk(clk), .rst(rst),
    .wr_en(hit.owner && guard_open && key_ok),
    .req_sec(req_id),
    .new_val(bus_wdata[OWN_W-1:0]),
    .owner(owner_sel)
  );

  mif_readback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OWN_W(OWN_W), .PROT_W(PROT_W)) u_rb (
    .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr),
    .lock(lock_q), .commit(commit_q), .owner(owner_sel), .prot(prot_q),
    .rdata(bus_rdata)
  );

  assign dma_wr_blk = prot_q[2];
  assign cpu_wr_blk = prot_q[1];
  assign fetch_blk  = prot_q[0];

  // R4: commit is sticky until reset
  p_commit_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    commit_q |=> commit_q);
  // R3/R4: a closed guard freezes the guarded fields
  p_guard_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    (lock_q || commit_q) |=> ($stable(owner_sel) && $stable(prot_q)));
  // R2: unprivileged cycles change nothing
  p_priv_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_priv |=> ($stable(lock_q) && $stable(commit_q) && $stable(prot_q) && $stable(owner_sel)));
  // R5: a bad key leaves the owner alone
  p_key_guard_r5: assert property (@(posedge clk) disable iff (rst)
    !key_ok |=> $stable(owner_sel));
endmodule

// File: tb/mif_own_regs_tb.sv
module mif_own_regs_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we, bus_priv, bus_rd, req_id;
  logic [31:0] bus_rdata;
  logic [1:0]  owner_sel;
  logic        dma_wr_blk, cpu_wr_blk, fetch_blk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] KEYW = 32'h93A5CE70;

  always #2.5 clk = ~clk;

  mif_own_regs u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_priv(bus_priv), .bus_rd(bus_rd), .req_id(req_id),
    .bus_rdata(bus_rdata), .owner_sel(owner_sel), .dma_wr_blk(dma_wr_blk),
    .cpu_wr_blk(cpu_wr_blk), .fetch_blk(fetch_blk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_we = 0; bus_rd = 0; bus_priv = 0; req_id = 0;
    bus_addr = '0; bus_wdata = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic pv, input logic id);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1; bus_priv = pv; req_id = id;
    @(negedge clk);
    bus_we = 0; bus_priv = 0; req_id = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 owner", {30'b0, owner_sel}, 0);
    chk("R1 blocks", {29'b0, dma_wr_blk, cpu_wr_blk, fetch_blk}, 0);
    rd(4'h0, d); chk("R1 lock rd", d, 0);
    rd(4'h2, d); chk("R1 commit rd", d, 0);
    rd(4'h4, d); chk("R1 owner rd", d, 0);
    rd(4'h8, d); chk("R1 prot rd", d, 0);
  endtask

  task automatic t_priv();
    logic [31:0] d;
    do_reset();
    wr(4'h0, 32'h1, 0, 0); rd(4'h0, d); chk("R2 lock unpriv", d, 0);
    wr(4'h8, 32'h7, 0, 0); chk("R2 prot unpriv", {29'b0, dma_wr_blk, cpu_wr_blk, fetch_blk}, 0);
    wr(4'h4, KEYW | 32'h1, 0, 0); chk("R2 owner unpriv", {30'b0, owner_sel}, 0);
    wr(4'h2, 32'h1, 0, 0); rd(4'h2, d); chk("R2 commit unpriv", d, 0);
  endtask

  task automatic t_prot();
    logic [31:0] d;
    do_reset();
    wr(4'h8, 32'h5, 1, 0);
    chk("R8 dma", {31'b0, dma_wr_blk}, 1);
    chk("R8 cpu", {31'b0, cpu_wr_blk}, 0);
    chk("R8 fetch", {31'b0, fetch_blk}, 1);
    rd(4'h8, d); chk("R8 rd 5", d, 5);
    wr(4'h8, 32'hFFFF_FFFA, 1, 0); rd(4'h8, d); chk("R8 upper ignored", d, 2);
    chk("R8 cpu only", {29'b0, dma_wr_blk, cpu_wr_blk, fetch_blk}, 2);
  endtask

  task automatic t_timing();
    do_reset();
    @(negedge clk);
    bus_addr = 4'h8; bus_wdata = 32'h4; bus_we = 1; bus_priv = 1;
    #1 chk("R10 before edge", {31'b0, dma_wr_blk}, 0);
    @(negedge clk);
    bus_we = 0; bus_priv = 0;
    chk("R10 after edge", {31'b0, dma_wr_blk}, 1);
  endtask

  task automatic t_key();
    logic [31:0] d;
    do_reset();
    wr(4'h4, 32'h93A5CE61, 1, 0); chk("R5 near key", {30'b0, owner_sel}, 0);
    wr(4'h4, 32'h13A5CE71, 1, 0); chk("R5 top bit key", {30'b0, owner_sel}, 0);
    wr(4'h4, KEYW | 32'h1, 1, 0); chk("R5 good key", {30'b0, owner_sel}, 1);
    wr(4'h4, KEYW | 32'hE, 1, 0); rd(4'h4, d); chk("R9 key bits read 0", d, 2);
  endtask

  task automatic t_grab();
    do_reset();
    wr(4'h4, KEYW | 32'h1, 1, 0); chk("R7 pri 01", {30'b0, owner_sel}, 1);
    wr(4'h4, KEYW | 32'h2, 1, 1); chk("R6 no steal from 01", {30'b0, owner_sel}, 1);
    wr(4'h4, KEYW | 32'h3, 1, 0); chk("R7 pri 11", {30'b0, owner_sel}, 3);
    wr(4'h4, KEYW | 32'h1, 1, 1); chk("R6 sec wrong code", {30'b0, owner_sel}, 3);
    wr(4'h4, KEYW | 32'h0, 1, 1); chk("R6 sec code 00", {30'b0, owner_sel}, 3);
    wr(4'h4, KEYW | 32'h2, 1, 1); chk("R6 grab from 11", {30'b0, owner_sel}, 2);
    wr(4'h4, KEYW | 32'h3, 1, 1); chk("R6 sec leave 10", {30'b0, owner_sel}, 2);
    wr(4'h4, KEYW | 32'h0, 1, 0); chk("R7 pri 00", {30'b0, owner_sel}, 0);
    wr(4'h4, KEYW | 32'h2, 1, 1); chk("R6 grab from 00", {30'b0, owner_sel}, 2);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    do_reset();
    wr(4'h0, 32'hFFFF_FFFF, 1, 0); rd(4'h0, d); chk("R3 lock rd", d, 1);
    wr(4'h8, 32'h7, 1, 0); chk("R3 prot locked", {29'b0, dma_wr_blk, cpu_wr_blk, fetch_blk}, 0);
    wr(4'h4, KEYW | 32'h1, 1, 0); chk("R3 owner locked", {30'b0, owner_sel}, 0);
    wr(4'h0, 32'h0, 1, 0); wr(4'h8, 32'h2, 1, 0);
    chk("R3 unlocked", {29'b0, dma_wr_blk, cpu_wr_blk, fetch_blk}, 2);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    do_reset();
    wr(4'h8, 32'h7, 1, 0);
    wr(4'h6, 32'hFFFF_FFFF, 1, 0);
    wr(4'hC, 32'h0, 1, 0);
    chk("R9 unmapped wr", {29'b0, dma_wr_blk, cpu_wr_blk, fetch_blk}, 7);
    rd(4'h1, d); chk("R9 rd 1", d, 0);
    rd(4'h6, d); chk("R9 rd 6", d, 0);
    rd(4'hC, d); chk("R9 rd C", d, 0);
    @(negedge clk); chk("R9 idle rdata", bus_rdata, 0);
  endtask

  task automatic t_commit();
    logic [31:0] d;
    do_reset();
    wr(4'h2, 32'h0, 1, 0); rd(4'h2, d); chk("R4 write 0 no set", d, 0);
    wr(4'h2, 32'h1, 1, 0); rd(4'h2, d); chk("R4 set", d, 1);
    wr(4'h8, 32'h7, 1, 0); chk("R4 prot frozen", {29'b0, dma_wr_blk, cpu_wr_blk, fetch_blk}, 0);
    wr(4'h4, KEYW | 32'h1, 1, 0); chk("R4 owner frozen", {30'b0, owner_sel}, 0);
    wr(4'h0, 32'h1, 1, 0); rd(4'h0, d); chk("R3 lock set after commit", d, 1);
    wr(4'h0, 32'h0, 1, 0); rd(4'h0, d); chk("R3 lock clear after commit", d, 0);
    wr(4'h8, 32'h7, 1, 0); chk("R4 unlocked still frozen", {29'b0, dma_wr_blk, cpu_wr_blk, fetch_blk}, 0);
    wr(4'h2, 32'h0, 1, 0); rd(4'h2, d); chk("R4 sticky", d, 1);
    do_reset(); rd(4'h2, d); chk("R4 reset clears", d, 0);
  endtask

  initial begin
    t_reset();
    t_priv();
    t_prot();
    t_timing();
    t_key();
    t_grab();
    t_lock();
    t_unmapped();
    t_commit();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule